// File: doc/BRIEF.md
# Class-Priority Per-Flow Queue Scheduler

This block keeps per-flow packet queues and decides which flow sends next. Each packet of a flow is a slot index taken from a shared pool of free slots. The packets of one flow are chained into a linked list through a link table. A flow table holds, for every flow, the first and last slot of its list, a written count, a read count and the service class the flow was given when it became active. The counts wrap, so the number of waiting packets is the written count minus the read count.

Only flow IDs sit in the scheduling queues, one FIFO per service class. A flow joins its class FIFO when its first waiting packet arrives. Each dequeue takes the flow at the front of the highest non-empty class. The flow's oldest slot is handed out and that slot goes back to the pool. If the flow still has packets waiting, it rejoins the back of the same class FIFO. This gives strict priority between classes and round-robin service between flows of one class. Every operation takes one clock cycle, whatever the queue lengths. The flow table, link table and pool are internal register arrays that stand in for an external SRAM. The packet data itself is handled outside the block.

Top module: `fsq_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, enq_done_o, enq_err_o and deq_valid_o are 0, and all class FIFOs are empty.
- R2: An accepted enqueue raises enq_done_o on the cycle after the request, with enq_ptr_o set to the slot taken from the front of the free pool. After reset the pool gives out slots 0, 1, 2, ... 63 in that order.
- R3: An enqueue made while the free pool is empty raises enq_err_o on the next cycle and does not raise enq_done_o. It changes no flow and takes no slot, so no later dequeue returns a packet for it.
- R4: Class 3 has the highest priority and class 0 the lowest. A dequeue always serves a flow of the highest class whose FIFO is non-empty at the start of the cycle.
- R5: Within one class, flows are served round-robin. A served flow that still has packets waiting goes to the back of its class FIFO.
- R6: For each flow, dequeues return slots in the order in which they were given out to that flow's enqueues.
- R7: A flow's class is set by the enqueue that finds the flow with no packets waiting. The class input of later enqueues is ignored while the flow still has packets waiting.
- R8: A flow whose last packet is dequeued leaves its class FIFO. Its next enqueue adds it again at the back of the FIFO for the new class given.
- R9: When an enqueue and a dequeue happen in the same cycle, the enqueue updates the flow state first. A flow served for its last packet while a packet for it arrives stays scheduled. A newly active flow joins the FIFO ahead of a served flow that rejoins the same class.
- R10: A dequeue request when all class FIFOs are empty at the start of the cycle gives deq_valid_o = 0 and has no effect. A flow enqueued in that same cycle is not served by it.
- R11: The slot returned by a dequeue goes to the back of the free pool in the same cycle, and is given out again only after all slots ahead of it.
- R12: deq_valid_o, deq_flow_o, deq_class_o and deq_ptr_o show the result of a dequeue request on the cycle after it, and deq_valid_o is 0 on every cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid_i | input | 1 | Enqueue one packet this cycle |
| enq_flow_i | input | 4 | Flow ID of the enqueued packet |
| enq_class_i | input | 2 | Service class, used only when the flow becomes active |
| deq_req_i | input | 1 | Request one dequeue this cycle |
| enq_done_o | output | 1 | Enqueue of the previous cycle was accepted |
| enq_err_o | output | 1 | Enqueue of the previous cycle was refused because the pool was empty |
| enq_ptr_o | output | 6 | Slot given to the accepted packet |
| deq_valid_o | output | 1 | A flow was served for the previous cycle's request |
| deq_flow_o | output | 4 | Flow ID that was served |
| deq_class_o | output | 2 | Class FIFO it was served from |
| deq_ptr_o | output | 6 | Slot of the packet that was served |

## Verification
The hardest case to reach from the ports is the same-cycle collision. In it, a flow with exactly one packet waiting is served while a new packet for that flow arrives. Then the flow's first slot has to be taken from the arriving slot, not from the link table. Directed sequences first build one-packet flows and then issue the colliding enqueue and dequeue together. Other directed sequences drain the 64-slot pool until enqueues are refused. A long random phase then mixes flows, classes and request rates, and a behavioural queue model predicts every output on every cycle.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    localparam int unsigned FLOWS_DEF   = 16;
    localparam int unsigned CLASSES_DEF = 4;
    localparam int unsigned SLOTS_DEF   = 64;

    typedef enum logic {
        RING_EMPTY = 1'b0,
        RING_SEQ   = 1'b1
    } ring_init_e;
endpackage

// File: rtl/fsq_ring.sv
module fsq_ring #(
    parameter int unsigned          DEPTH = 16,
    parameter int unsigned          W     = 4,
    parameter fsq_pkg::ring_init_e  INIT  = fsq_pkg::RING_EMPTY,
    localparam int unsigned         IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned         CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_a,
    input  logic [W-1:0]  data_a,
    input  logic          push_b,
    input  logic [W-1:0]  data_b,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [IW-1:0]           rd;
        logic [IW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } ring_t;

    ring_t st_d, st_q;

    function automatic ring_t ring_reset();
        ring_t r;
        r = '0;
        if (INIT == fsq_pkg::RING_SEQ) begin
            for (int i = 0; i < DEPTH; i++) r.mem[i] = W'(i);
            r.cnt = CW'(DEPTH);
        end
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (pop) st_d.rd = st_q.rd + IW'(1);
        if (push_a) st_d.mem[st_q.wr] = data_a;
        if (push_b) st_d.mem[st_q.wr + IW'(push_a)] = data_b;
        st_d.wr  = st_q.wr + IW'(push_a) + IW'(push_b);
        st_d.cnt = st_q.cnt + CW'(push_a) + CW'(push_b) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ring_reset();
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;
endmodule

// File: rtl/fsq_pick.sv
module fsq_pick #(
    parameter  int unsigned NCLS  = 4,
    localparam int unsigned CLS_W = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic [NCLS-1:0]  nonempty,
    output logic             any,
    output logic [CLS_W-1:0] sel
);
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int c = 0; c < NCLS; c++) begin
            if (nonempty[c]) begin
                any = 1'b1;
                sel = CLS_W'(c);
            end
        end
    end
endmodule

// File: rtl/fsq_sched.sv
module fsq_sched #(
    parameter  int unsigned NFLOW  = fsq_pkg::FLOWS_DEF,
    parameter  int unsigned NCLS   = fsq_pkg::CLASSES_DEF,
    parameter  int unsigned NPTR   = fsq_pkg::SLOTS_DEF,
    localparam int unsigned FLOW_W = $clog2(NFLOW),
    localparam int unsigned CLS_W  = $clog2(NCLS),
    localparam int unsigned PTR_W  = $clog2(NPTR),
    localparam int unsigned CNT_W  = PTR_W + 1,
    localparam int unsigned PCW    = $clog2(NPTR + 1),
    localparam int unsigned QCW    = $clog2(NFLOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid_i,
    input  logic [FLOW_W-1:0] enq_flow_i,
    input  logic [CLS_W-1:0]  enq_class_i,
    input  logic              deq_req_i,
    output logic              enq_done_o,
    output logic              enq_err_o,
    output logic [PTR_W-1:0]  enq_ptr_o,
    output logic              deq_valid_o,
    output logic [FLOW_W-1:0] deq_flow_o,
    output logic [CLS_W-1:0]  deq_class_o,
    output logic [PTR_W-1:0]  deq_ptr_o
);
    typedef struct packed {
        logic [NFLOW-1:0][PTR_W-1:0] head;
        logic [NFLOW-1:0][PTR_W-1:0] tail;
        logic [NFLOW-1:0][CNT_W-1:0] wcnt;
        logic [NFLOW-1:0][CNT_W-1:0] rcnt;
        logic [NFLOW-1:0][CLS_W-1:0] cls;
        logic [NPTR-1:0][PTR_W-1:0]  link;
        logic                        enq_done;
        logic                        enq_err;
        logic [PTR_W-1:0]            enq_ptr;
        logic                        deq_valid;
        logic [FLOW_W-1:0]           deq_flow;
        logic [CLS_W-1:0]            deq_cls;
        logic [PTR_W-1:0]            deq_ptr;
    } sched_t;

    sched_t st_d, st_q;

    // class rings and pool
    logic [NCLS-1:0]   qpush_a, qpush_b, qpop, qne;
    logic [FLOW_W-1:0] qhead [NCLS];
    logic [QCW-1:0]    qcnt  [NCLS];
    logic [PTR_W-1:0]  pool_head;
    logic [PCW-1:0]    pool_cnt;
    logic              pick_any;
    logic [CLS_W-1:0]  pick_sel;

    // per-cycle decisions
    logic              enq_ok, enq_idle, deq_ok, deq_more;
    logic [FLOW_W-1:0] deq_fid;
    logic [PTR_W-1:0]  rel_ptr;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        fsq_ring #(
            .DEPTH (NFLOW),
            .W     (FLOW_W),
            .INIT  (fsq_pkg::RING_EMPTY)
        ) u_q (
            .clk    (clk),
            .rst_n  (rst_n),
            .push_a (qpush_a[c]),
            .data_a (enq_flow_i),
            .push_b (qpush_b[c]),
            .data_b (deq_fid),
            .pop    (qpop[c]),
            .head   (qhead[c]),
            .count  (qcnt[c])
        );
        assign qne[c] = (qcnt[c] != '0);
    end

    fsq_ring #(
        .DEPTH (NPTR),
        .W     (PTR_W),
        .INIT  (fsq_pkg::RING_SEQ)
    ) u_pool (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_a (deq_ok),
        .data_a (rel_ptr),
        .push_b (1'b0),
        .data_b ('0),
        .pop    (enq_ok),
        .head   (pool_head),
        .count  (pool_cnt)
    );

    fsq_pick #(.NCLS(NCLS)) u_pick (
        .nonempty (qne),
        .any      (pick_any),
        .sel      (pick_sel)
    );

    always_comb begin
        st_d      = st_q;
        qpush_a   = '0;
        qpush_b   = '0;
        qpop      = '0;
        enq_idle  = 1'b0;
        deq_more  = 1'b0;
        st_d.enq_done  = 1'b0;
        st_d.deq_valid = 1'b0;

        // enqueue first, so a same-cycle dequeue sees the new packet
        enq_ok       = enq_valid_i && (pool_cnt != '0);
        st_d.enq_err = enq_valid_i && !enq_ok;
        if (enq_ok) begin
            enq_idle = (st_q.wcnt[enq_flow_i] - st_q.rcnt[enq_flow_i]) == '0;
            st_d.enq_done = 1'b1;
            st_d.enq_ptr  = pool_head;
            if (enq_idle) begin
                st_d.head[enq_flow_i] = pool_head;
                st_d.cls[enq_flow_i]  = enq_class_i;
                qpush_a[enq_class_i]  = 1'b1;
            end else begin
                st_d.link[st_q.tail[enq_flow_i]] = pool_head;
            end
            st_d.tail[enq_flow_i] = pool_head;
            st_d.wcnt[enq_flow_i] = st_q.wcnt[enq_flow_i] + CNT_W'(1);
        end

        // dequeue from the highest non-empty class
        deq_ok  = deq_req_i && pick_any;
        deq_fid = qhead[pick_sel];
        rel_ptr = st_q.head[deq_fid];
        if (deq_ok) begin
            qpop[pick_sel]     = 1'b1;
            st_d.deq_valid     = 1'b1;
            st_d.deq_flow      = deq_fid;
            st_d.deq_cls       = pick_sel;
            st_d.deq_ptr       = rel_ptr;
            st_d.rcnt[deq_fid] = st_q.rcnt[deq_fid] + CNT_W'(1);
            deq_more = (st_d.wcnt[deq_fid] - st_d.rcnt[deq_fid]) != '0;
            if (deq_more) begin
                qpush_b[pick_sel] = 1'b1;
                if (enq_ok && enq_flow_i == deq_fid
                    && st_q.head[deq_fid] == st_q.tail[deq_fid])
                    st_d.head[deq_fid] = pool_head;
                else
                    st_d.head[deq_fid] = st_q.link[rel_ptr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enq_done_o  = st_q.enq_done;
    assign enq_err_o   = st_q.enq_err;
    assign enq_ptr_o   = st_q.enq_ptr;
    assign deq_valid_o = st_q.deq_valid;
    assign deq_flow_o  = st_q.deq_flow;
    assign deq_class_o = st_q.deq_cls;
    assign deq_ptr_o   = st_q.deq_ptr;
endmodule

// File: rtl/fsq_sched_chk.sv
module fsq_sched_chk #(
    parameter int unsigned NCLS  = 4,
    parameter int unsigned CLS_W = 2,
    parameter int unsigned PTR_W = 6,
    parameter int unsigned PCW   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic             deq_req,
    input logic             enq_done,
    input logic             enq_err,
    input logic [PTR_W-1:0] enq_ptr,
    input logic             deq_valid,
    input logic [CLS_W-1:0] deq_cls,
    input logic [PTR_W-1:0] deq_ptr,
    input logic [NCLS-1:0]  qne,
    input logic [PCW-1:0]   pool_cnt
);
    // R2
    enq_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |=> (enq_done != enq_err));

    // R2
    enq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enq_valid |=> (!enq_done && !enq_err));

    // R3
    pool_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && pool_cnt == '0) |=> enq_err);

    // R12
    no_spurious_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !deq_req |=> !deq_valid);

    // R10
    empty_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_req && qne == '0) |=> !deq_valid);

    // R4
    strict_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> (($past(qne) >> deq_cls) == NCLS'(1)));

    // R11
    slot_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_done && deq_valid) |-> (enq_ptr != deq_ptr));
endmodule

bind fsq_sched fsq_sched_chk #(
    .NCLS  (NCLS),
    .CLS_W (CLS_W),
    .PTR_W (PTR_W),
    .PCW   (PCW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid_i),
    .deq_req   (deq_req_i),
    .enq_done  (enq_done_o),
    .enq_err   (enq_err_o),
    .enq_ptr   (enq_ptr_o),
    .deq_valid (deq_valid_o),
    .deq_cls   (deq_class_o),
    .deq_ptr   (deq_ptr_o),
    .qne       (qne),
    .pool_cnt  (pool_cnt)
);

// File: tb/fsq_sched_bench.sv
module fsq_sched_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enq_valid_i = 1'b0;
    logic [3:0] enq_flow_i = '0;
    logic [1:0] enq_class_i = '0;
    logic       deq_req_i = 1'b0;
    logic       enq_done_o, enq_err_o, deq_valid_o;
    logic [5:0] enq_ptr_o, deq_ptr_o;
    logic [3:0] deq_flow_o;
    logic [1:0] deq_class_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural reference model
    int pool[$];
    int cq[4][$];
    int fq[16][$];

    always #5 clk = ~clk;

    fsq_sched u_fsq_sched (
        .clk(clk), .rst_n(rst_n),
        .enq_valid_i(enq_valid_i), .enq_flow_i(enq_flow_i),
        .enq_class_i(enq_class_i), .deq_req_i(deq_req_i),
        .enq_done_o(enq_done_o), .enq_err_o(enq_err_o), .enq_ptr_o(enq_ptr_o),
        .deq_valid_o(deq_valid_o), .deq_flow_o(deq_flow_o),
        .deq_class_o(deq_class_o), .deq_ptr_o(deq_ptr_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit ev, input int f, input int c, input bit dr, input string tag);
        int e_done = 0, e_err = 0, e_ptr = 0;
        int d_v = 0, d_f = 0, d_p = 0, d_c = 0, sel = -1;
        @(negedge clk);
        enq_valid_i = ev; enq_flow_i = 4'(f); enq_class_i = 2'(c); deq_req_i = dr;
        if (dr) for (int k = 3; k >= 0; k--) if (sel < 0 && cq[k].size() > 0) sel = k;
        if (ev) begin
            if (pool.size() == 0) e_err = 1;
            else begin
                e_ptr = pool.pop_front();
                e_done = 1;
                if (fq[f].size() == 0) cq[c].push_back(f);
                fq[f].push_back(e_ptr);
            end
        end
        if (sel >= 0) begin
            d_v = 1; d_c = sel;
            d_f = cq[sel].pop_front();
            d_p = fq[d_f].pop_front();
            if (fq[d_f].size() > 0) cq[sel].push_back(d_f);
            pool.push_back(d_p);
        end
        @(posedge clk); #2;
        chk(tag, "enq_done", enq_done_o, e_done);
        chk(tag, "enq_err", enq_err_o, e_err);
        if (e_done) chk(tag, "enq_ptr", enq_ptr_o, e_ptr);
        chk(tag, "deq_valid", deq_valid_o, d_v);
        if (d_v) begin
            chk(tag, "deq_flow", deq_flow_o, d_f);
            chk(tag, "deq_class", deq_class_o, d_c);
            chk(tag, "deq_ptr", deq_ptr_o, d_p);
        end
    endtask

    function automatic bit model_busy();
        for (int k = 0; k < 4; k++) if (cq[k].size() > 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic drain(input string tag);
        while (model_busy()) step(0, 0, 0, 1, tag);
        step(0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) pool.push_back(i);
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs low during reset
        chk("R1", "enq_done", enq_done_o, 0);
        chk("R1", "deq_valid", deq_valid_o, 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, "R1");
        step(0, 0, 0, 1, "R1/R10");      // empty after reset

        // R2 / R12: slot order and one-cycle latency
        step(1, 2, 1, 0, "R2");
        step(1, 2, 1, 0, "R2");
        step(1, 2, 3, 0, "R7");          // class ignored, flow 2 stays class 1
        step(1, 9, 1, 0, "R12");
        step(1, 5, 3, 0, "R2");
        step(1, 7, 0, 0, "R2");
        // R4 then R5 / R6
        step(0, 0, 0, 1, "R4");
        step(0, 0, 0, 1, "R5");
        step(0, 0, 0, 1, "R5");
        step(0, 0, 0, 1, "R6");
        step(0, 0, 0, 1, "R6");
        step(0, 0, 0, 1, "R4");
        step(0, 0, 0, 1, "R10");
        // R8: flow 2 re-enters in a new class
        step(1, 2, 3, 0, "R8");
        step(1, 3, 3, 0, "R8");
        step(1, 2, 0, 0, "R8");
        drain("R8");

        // R9: one-packet flow served while its packet arrives
        step(1, 4, 2, 0, "R9");
        step(1, 4, 0, 1, "R9");
        step(0, 0, 0, 1, "R9");
        step(0, 0, 0, 1, "R9");
        // R9: newly active flow joins ahead of the rejoining flow
        step(1, 6, 2, 0, "R9");
        step(1, 6, 2, 0, "R9");
        step(1, 8, 2, 0, "R9");
        step(1, 10, 2, 1, "R9");
        drain("R9");

        // R10: enqueue into empty queues with a same-cycle request
        step(1, 1, 0, 1, "R10");
        step(0, 0, 0, 1, "R10");
        drain("R10");

        // R3: exhaust the pool
        for (int i = 0; i < 66; i++) step(1, i % 16, i % 4, 0, "R3");
        step(1, 3, 1, 0, "R3");
        drain("R3");

        // R11 with R5/R6: random mixed traffic
        for (int i = 0; i < 3000; i++)
            step(($urandom % 3) != 0, $urandom % 16, $urandom % 4,
                 ($urandom % 2) == 0, "R11/R5/R6");
        drain("R11");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule